// File: doc/BRIEF.md
# Two-Bit-Per-Cell Lookahead Ripple Adder

This block adds two unsigned operands and a carry input. The result, including the carry out of the top bit, is captured in an output register. The datapath is a chain of identical cells, and each cell handles one pair of adjacent bit positions. Before the incoming carry arrives, each cell forms two group terms from its four operand bits. The first is a generate term, meaning the pair carries out on its own. The second is a not-kill term, meaning every position of the pair has at least one operand bit set. The outgoing carry is then the generate term ORed with the incoming carry ANDed with the not-kill term, so the ripple path crosses each cell through a single AND-OR stage.

Inside a cell, the lower sum bit and the carry into the upper position use the usual full-adder functions. Each sum bit is written in majority-complement form: the inverted carry out of that position, ANDed with the OR of its three inputs, ORed with the AND of all three. The number of cells is a parameter, and the operand width is twice the cell count. The default is sixteen cells, giving 32 bits.

Top module: `radix4_adder`

## Requirements
- R1: On every clock edge with `rst` low, `{cout,sum}` is loaded with the 33-bit value `a + b + cin` of the inputs at that edge, so the result appears one cycle after the operands.
- R2: On a clock edge with `rst` high, `sum` and `cout` are cleared to zero whatever the operands and carry input are.
- R3: Cell i handles operand bits 2i+1 and 2i. Its carry-in is the carry-out of cell i-1, and cell 0 takes `cin`. The carry leaving cell i equals bit 2i+2 of the sum of the operands' low 2i+2 bits plus `cin`.
- R4: The group generate term of a cell is 1 exactly when its two operand pairs, read as 2-bit numbers, add to 4 or more with no carry-in.
- R5: The group not-kill term of a cell is 1 exactly when position 2i+1 and position 2i each have at least one operand bit set. It is 0 for the pair 2+2 even though that pair carries out.
- R6: A cell's carry-out is 1 whenever its generate term is 1, equals its generate term whenever its not-kill term is 0, and otherwise follows its carry-in.
- R7: The worst-case ripple case works in both directions. With `a` all ones and `b` zero, `cin`=1 gives `sum`=0 and `cout`=1, and `cin`=0 gives `sum` all ones and `cout`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a | input | 2*CELLS | First operand |
| b | input | 2*CELLS | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 2*CELLS | Registered sum bits |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
The clocked checks sample the combinational cell outputs at the rising edge. They therefore assume that `a`, `b` and `cin` are known and settled at every edge, and that the result register is compared only on an edge that follows a non-reset edge. The stimulus meets both conditions. It changes the operands and the carry input only on the falling edge, and it reads the outputs on the next falling edge. It releases reset on a falling edge before any operand that is to be checked is applied.

// File: rtl/radix4_pkg.sv
package radix4_pkg;
  // pair-level lookahead terms computed from operands only
  typedef struct packed {
    logic gen;   // pair carries out on its own
    logic nkill; // pair passes an incoming carry
  } grp_t;
endpackage

// File: rtl/r4_group.sv
module r4_group
  import radix4_pkg::*;
(
  input  logic [1:0] x,
  input  logic [1:0] y,
  output grp_t       grp
);
  logic any_hi, any_lo, both_hi, both_lo;

  always_comb begin
    any_hi    = x[1] | y[1];
    any_lo    = x[0] | y[0];
    both_hi   = x[1] & y[1];
    both_lo   = x[0] & y[0];
    grp.gen   = both_hi | (any_hi & both_lo);
    grp.nkill = any_hi & any_lo;
  end
endmodule

// File: rtl/r4_cell.sv
module r4_cell
  import radix4_pkg::*;
(
  input  logic [1:0] x,
  input  logic [1:0] y,
  input  logic       ci,
  output logic [1:0] s,
  output logic       co,
  output grp_t       grp
);
  logic mid_c;

  r4_group u_grp (
    .x   (x),
    .y   (y),
    .grp (grp)
  );

  always_comb begin
    // carry into the upper position
    mid_c = ((x[0] | y[0]) & ci) | (x[0] & y[0]);
    // single AND-OR stage on the ripple path
    co    = (ci & grp.nkill) | grp.gen;
    // majority-complement sums
    s[0]  = (~mid_c & (x[0] | y[0] | ci)) | (x[0] & y[0] & ci);
    s[1]  = (~co & (x[1] | y[1] | mid_c)) | (x[1] & y[1] & mid_c);
  end
endmodule

// File: rtl/r4_chain.sv
module r4_chain
  import radix4_pkg::*;
#(
  parameter int CELLS = 16,
  localparam int W = 2 * CELLS
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  output logic [W-1:0]     s,
  output logic [CELLS:0]   carry,
  output grp_t [CELLS-1:0] grp
);
  assign carry[0] = cin;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    r4_cell u_cell (
      .x   (a[2*i+1 -: 2]),
      .y   (b[2*i+1 -: 2]),
      .ci  (carry[i]),
      .s   (s[2*i+1 -: 2]),
      .co  (carry[i+1]),
      .grp (grp[i])
    );
  end
endmodule

// File: rtl/radix4_adder.sv
module radix4_adder
  import radix4_pkg::*;
#(
  parameter int CELLS = 16,
  localparam int W = 2 * CELLS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0]     s_comb;
  logic [CELLS:0]   carry;
  grp_t [CELLS-1:0] grp;

  r4_chain #(.CELLS(CELLS)) u_chain (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .s     (s_comb),
    .carry (carry),
    .grp   (grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= s_comb;
      cout <= carry[CELLS];
    end
  end

  // R1
  result_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout, sum} == ($past({1'b0, a}) + $past({1'b0, b}) + {{W{1'b0}}, $past(cin)})));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sum == '0 && !cout));

  for (genvar i = 0; i < CELLS; i++) begin : g_chk
    localparam int LW = 2 * i + 2;
    logic [LW:0] low_ref;
    logic [2:0]  pair_sum;
    assign low_ref  = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]} + {{LW{1'b0}}, cin};
    assign pair_sum = {1'b0, a[2*i+1 -: 2]} + {1'b0, b[2*i+1 -: 2]};

    // R3
    low_slice_chk: assert property (@(posedge clk) disable iff (rst)
      {carry[i+1], s_comb[LW-1:0]} == low_ref);
    // R4
    group_gen_chk: assert property (@(posedge clk) disable iff (rst)
      grp[i].gen == (pair_sum >= 3'd4));
    // R5
    group_nkill_chk: assert property (@(posedge clk) disable iff (rst)
      grp[i].nkill == ((a[2*i+1] | b[2*i+1]) & (a[2*i] | b[2*i])));
    // R6
    gen_forces_chk: assert property (@(posedge clk) disable iff (rst)
      grp[i].gen |-> carry[i+1]);
    // R6
    killed_chk: assert property (@(posedge clk) disable iff (rst)
      !grp[i].nkill |-> (carry[i+1] == grp[i].gen));
    // R6
    pass_chk: assert property (@(posedge clk) disable iff (rst)
      (grp[i].nkill && !grp[i].gen) |-> (carry[i+1] == carry[i]));
  end
endmodule

// File: tb/radix4_adder_test.sv
module radix4_adder_test;
  localparam int CELLS = 16;
  localparam int W = 2 * CELLS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  radix4_adder #(.CELLS(CELLS)) uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on falling edge, read on the next falling edge (one register)
  task automatic add_and_check(input string req, input logic [W-1:0] x,
                               input logic [W-1:0] y, input logic c);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    a = '1; b = '1; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R2 reset state", {cout, sum}, '0);
    rst = 1'b0;
  endtask

  task automatic t_worst_case;
    add_and_check("R7 ripple cin=1", '1, '0, 1'b1);
    add_and_check("R7 ripple cin=0", '1, '0, 1'b0);
    add_and_check("R7 ripple b side", '0, '1, 1'b1);
  endtask

  task automatic t_group_terms;
    add_and_check("R4 generate 2+2", 32'h2, 32'h2, 1'b0);
    add_and_check("R4 generate 3+1", 32'h3, 32'h1, 1'b0);
    add_and_check("R5 notkill 1+2 cin", 32'h1, 32'h2, 1'b1);
    add_and_check("R5 notkill 0+3 cin", 32'h0, 32'h3, 1'b1);
    add_and_check("R6 killed 1+1 cin", 32'h1, 32'h1, 1'b1);
    add_and_check("R6 top pair generate", 32'hC000_0000, 32'h4000_0000, 1'b0);
    add_and_check("R6 top pair pass", 32'hBFFF_FFFF, 32'h4000_0000, 1'b1);
  endtask

  task automatic t_chain;
    for (int k = 0; k < CELLS; k++) begin
      logic [W-1:0] m;
      m = (W'(1) << (2 * k + 2)) - W'(1);
      add_and_check("R3 carry to cell boundary", m, '0, 1'b1);
    end
    add_and_check("R3 alternating pairs", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 10000; k++)
      add_and_check("R1 random", W'($urandom), W'($urandom), 1'($urandom));
  endtask

  task automatic t_reset_midway;
    @(negedge clk);
    a = 32'h1234_5678; b = 32'hFFFF_0000; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R2 reset mid-run", {cout, sum}, '0);
    rst = 1'b0;
    add_and_check("R1 after reset", 32'h1234_5678, 32'hFFFF_0000, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_worst_case();
    t_group_terms();
    t_chain();
    t_random();
    t_reset_midway();
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule